// File: doc/BRIEF.md
# Register Set Block Transfer Sequencer

The sequencer moves any subset of a sixteen-entry register file to or from a run of consecutive memory locations. The register file holds eight data registers and eight address registers. Software-visible selection is a 16-bit mask. Mask bits 0 to 7 select data registers 0 to 7, and mask bits 8 to 15 select address registers 0 to 7. The register index placed on the register-file ports equals the mask bit position. Unselected registers are skipped and leave no hole in memory.

A single start strobe latches the mask, the direction, the size, the addressing variant and a start address.

- In ascending mode the selected registers are visited from the lowest index to the highest. Addresses climb from the start address by 2 bytes per register in word mode, or by 4 bytes in long mode.
- In predecrement mode the visit order is reversed. The address pointer is lowered by one stride before each access. The final pointer value is reported so the caller can write it back.

The sequencer issues one memory transfer per accepted valid/ready handshake. It pulses done when the last transfer is accepted.

The register file has a combinational read port and a write port. In a load, memory returns data combinationally alongside ready, and the register is written in the handshake cycle.

Top module: `regset_xfer_seq`

## Requirements
- R1: In ascending mode, only registers whose mask bit is set are transferred. They are visited in increasing mask bit position: data registers 0 to 7 (bits 0 to 7), then address registers 0 to 7 (bits 8 to 15).
- R2: In word mode (`long_i`=0), ascending transfer k (counted from 0) uses address start + 2·k.
- R3: In long mode (`long_i`=1), ascending transfer k uses address start + 4·k.
- R4: A store (`load_i`=0) drives `mem_we_o`=1 and reads the register whose index is on `rf_raddr_o`. Its write data is the full 32-bit register in long mode, or the register's low 16 bits zero-extended in word mode.
- R5: A load (`load_i`=1) drives `mem_we_o`=0. In the handshake cycle it asserts `rf_we_o` with `rf_waddr_o` equal to the visited index. The write value is `mem_rdata_i` unchanged in long mode, or bits 15:0 of `mem_rdata_i` sign-extended to 32 bits in word mode.
- R6: An all-zero mask raises `done_o` in the cycle after start and makes no memory request. `end_addr_o` then equals the start address.
- R7: While `mem_valid_o` is high and `mem_ready_i` is low, the request is held with the same address. Exactly one register is retired per accepted handshake.
- R8: In predecrement mode (`pre_i`=1), registers are visited in decreasing mask bit position (address register 7 down to data register 0). Transfer k uses address start − stride·(k+1), and `end_addr_o` ends at start − stride·count.
- R9: In ascending mode, `end_addr_o` equals start + stride·count when `done_o` is high.
- R10: `done_o` is a one-cycle pulse in the cycle after the last handshake, after which `busy_o` is low. A start strobe while busy is ignored and does not alter the running sequence.
- R11: During reset, `mem_valid_o`, `done_o`, `busy_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| mask_i | input | 16 | Register selection mask |
| load_i | input | 1 | 1: memory to registers, 0: registers to memory |
| long_i | input | 1 | 1: 32-bit elements, 0: 16-bit elements |
| pre_i | input | 1 | 1: predecrement variant |
| base_addr_i | input | 32 | Start address |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Byte address of the request |
| mem_we_o | output | 1 | Request is a write |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| end_addr_o | output | 32 | Final address pointer |

## Verification
The bench builds the block with its default parameters: eight registers per half, 32-bit data and 32-bit addresses. The mask therefore spans both halves, so the crossing from the last data register to the first address register can be checked in both visit orders. Full 32-bit addresses let predecrement runs descend below the start address without wrap. The chosen word-mode data values have both clear and set bit 15, so zero-extension on stores and sign-extension on loads are both exercised.

// File: rtl/regset_xfer_pkg.sv
package regset_xfer_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_RUN  = 2'd1,
    XS_FIN  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/regset_pick.sv
// Picks the next pending register: lowest index ascending, highest when descending.
module regset_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  pend_i,
  input  logic          descend_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  sel_o
);
  always_comb begin
    idx_o = '0;
    if (descend_i) begin
      for (int i = 0; i < N; i++)
        if (pend_i[i]) idx_o = IW'(i);
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (pend_i[i]) idx_o = IW'(i);
    end
    sel_o = '0;
    if (|pend_i) sel_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/regset_addr.sv
// Address pointer: post-step upward, or pre-step downward in predecrement mode.
module regset_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          long_i,
  input  logic          pre_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] acc_o
);
  function automatic logic [AW-1:0] stride_of(input logic lng);
    return lng ? AW'(4) : AW'(2);
  endfunction

  logic [AW-1:0] ptr_q;

  assign acc_o = pre_i ? (ptr_q - stride_of(long_i)) : ptr_q;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= base_i;
    else if (step_i) ptr_q <= pre_i ? (ptr_q - stride_of(long_i)) : (ptr_q + stride_of(long_i));
  end

  // R8: after a predecrement step the pointer lands on the address just used
  a_r8_pre_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && pre_i && !load_i) |=> (ptr_q == $past(acc_o)));
  // R2 / R3: an ascending step moves the pointer past the address just used
  a_r3_post_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !pre_i && !load_i) |=> (ptr_q != $past(acc_o)));
endmodule

// File: rtl/regset_fmt.sv
// Element formatting between register width and transfer size.
module regset_fmt #(
  parameter int DW = 32
) (
  input  logic          long_i,
  input  logic [DW-1:0] rf_rdata_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rf_wdata_o
);
  localparam int HW = DW / 2;

  function automatic logic [DW-1:0] store_fmt(input logic lng, input logic [DW-1:0] v);
    return lng ? v : {{(DW-HW){1'b0}}, v[HW-1:0]};
  endfunction

  function automatic logic [DW-1:0] load_fmt(input logic lng, input logic [DW-1:0] v);
    return lng ? v : {{(DW-HW){v[HW-1]}}, v[HW-1:0]};
  endfunction

  assign wdata_o    = store_fmt(long_i, rf_rdata_i);
  assign rf_wdata_o = load_fmt(long_i, mem_rdata_i);
endmodule

// File: rtl/regset_xfer_seq.sv
module regset_xfer_seq
  import regset_xfer_pkg::*;
#(
  parameter int HALF_REGS = 8,
  parameter int DW        = 32,
  parameter int AW        = 32,
  localparam int NREG     = 2 * HALF_REGS,
  localparam int IW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NREG-1:0] mask_i,
  input  logic            load_i,
  input  logic            long_i,
  input  logic            pre_i,
  input  logic [AW-1:0]   base_addr_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_we_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [IW-1:0]   rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   end_addr_o
);
  xfer_state_e     state_q;
  logic [NREG-1:0] pend_q;
  logic            ld_q, lg_q, pre_q;

  // named internal events
  logic            accept;    // start taken
  logic            fire;      // one handshake
  logic            last_fire; // handshake retiring the final register
  logic [IW-1:0]   cur_idx;
  logic [NREG-1:0] cur_sel;
  logic [NREG-1:0] pend_next;

  assign accept    = (state_q == XS_IDLE) && start_i;
  assign fire      = mem_valid_o && mem_ready_i;
  assign pend_next = pend_q & ~cur_sel;
  assign last_fire = fire && (pend_next == '0);

  regset_pick #(.N(NREG), .IW(IW)) u_pick (
    .pend_i   (pend_q),
    .descend_i(pre_q),
    .idx_o    (cur_idx),
    .sel_o    (cur_sel)
  );

  regset_addr #(.AW(AW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(accept),
    .base_i(base_addr_i),
    .step_i(fire),
    .long_i(lg_q),
    .pre_i (pre_q),
    .ptr_o (end_addr_o),
    .acc_o (mem_addr_o)
  );

  regset_fmt #(.DW(DW)) u_fmt (
    .long_i     (lg_q),
    .rf_rdata_i (rf_rdata_i),
    .mem_rdata_i(mem_rdata_i),
    .wdata_o    (mem_wdata_o),
    .rf_wdata_o (rf_wdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      pend_q  <= '0;
      ld_q    <= 1'b0;
      lg_q    <= 1'b0;
      pre_q   <= 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: if (start_i) begin
          pend_q  <= mask_i;
          ld_q    <= load_i;
          lg_q    <= long_i;
          pre_q   <= pre_i;
          state_q <= (mask_i == '0) ? XS_FIN : XS_RUN;
        end
        XS_RUN: if (fire) begin
          pend_q <= pend_next;
          if (last_fire) state_q <= XS_FIN;
        end
        XS_FIN:  state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign mem_valid_o = (state_q == XS_RUN);
  assign mem_we_o    = mem_valid_o && !ld_q;
  assign rf_raddr_o  = cur_idx;
  assign rf_waddr_o  = cur_idx;
  assign rf_we_o     = fire && ld_q;
  assign busy_o      = (state_q != XS_IDLE);
  assign done_o      = (state_q == XS_FIN);

  // R1: at most one register chosen at a time
  a_r1_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cur_sel));
  // R7: a stalled request keeps its address and register
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(rf_raddr_o)));
  // R7: each handshake retires exactly one pending register
  a_r7_one_per_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
  // R10: pending set only changes on a handshake, so a busy start is ignored
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_RUN && !fire) |=> $stable(pend_q));
  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: register writes only on a load handshake
  a_r5_rf_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_valid_o && mem_ready_i && !mem_we_o));
  // R6: empty mask finishes at once without a request
  a_r6_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mask_i == '0) |=> (done_o && !mem_valid_o));
endmodule

// File: tb/regset_xfer_seq_tb.sv
`timescale 1ns/1ps
module regset_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic        load_i = 1'b0, long_i = 1'b0, pre_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic        mem_valid_o, mem_ready_i = 1'b0, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o, end_addr_o;
  logic        rf_we_o, busy_o, done_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] reg_val(input int i);
    return {8'(8'h30 + i), 8'(i * 17), 16'(32'h7F00 + i * 32'h1111)};
  endfunction
  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0] ^ 16'h43C0};
  endfunction

  assign rf_rdata_i  = reg_val(int'(rf_raddr_o));
  assign mem_rdata_i = mem_val(mem_addr_o);

  regset_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
    .load_i(load_i), .long_i(long_i), .pre_i(pre_i), .base_addr_i(base_addr_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
    .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .busy_o(busy_o),
    .done_o(done_o), .end_addr_o(end_addr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stimulus vectors: mask, load, long, predecrement, base, ready pattern
  localparam logic [15:0] V_MASK [8] = '{16'h4297, 16'hFFFF, 16'h8001, 16'h00F0,
                                         16'h0380, 16'hFFFF, 16'h1234, 16'h0000};
  localparam bit          V_LD   [8] = '{0, 0, 1, 1, 0, 0, 1, 0};
  localparam bit          V_LG   [8] = '{0, 1, 0, 1, 0, 1, 0, 0};
  localparam bit          V_PRE  [8] = '{0, 0, 0, 0, 1, 1, 1, 0};
  localparam logic [31:0] V_BASE [8] = '{32'h4000, 32'h1000, 32'h9000, 32'h2000,
                                         32'h3000, 32'h8000, 32'h2100, 32'h5000};
  localparam int          V_MODE [8] = '{0, 1, 2, 0, 1, 0, 2, 0};

  task automatic run_op(input logic [15:0] m, input bit ld, input bit lg, input bit pr,
                        input logic [31:0] base, input int mode, input int hold, input bit poke);
    int ord[16];
    int n = 0;
    int k = 0;
    bit seen = 0;
    logic [31:0] st = lg ? 32'd4 : 32'd2;
    logic [31:0] ea, ed;
    string ordr = pr ? "R8" : "R1";
    string adr  = pr ? "R8" : (lg ? "R3" : "R2");
    if (pr) begin
      for (int i = 15; i >= 0; i--) if (m[i]) begin ord[n] = i; n++; end
    end else begin
      for (int i = 0; i < 16; i++) if (m[i]) begin ord[n] = i; n++; end
    end
    @(negedge clk);
    mask_i = m; load_i = ld; long_i = lg; pre_i = pr; base_addr_i = base;
    start_i = 1'b1; mem_ready_i = 1'b0;
    for (int c = 0; c < 300 && !seen; c++) begin
      @(negedge clk);
      start_i = poke && (c == 2);
      if (poke && c == 2) begin mask_i = 16'hFFFF; base_addr_i = 32'h0; end
      if (c < hold) mem_ready_i = 1'b0;
      else if (mode == 1) mem_ready_i = c[0];
      else if (mode == 2) mem_ready_i = (c % 3 == 0);
      else mem_ready_i = 1'b1;
      #1;
      if (done_o) seen = 1;
      else begin
        if (c < hold && n > 0) begin
          ea = pr ? base - st : base;
          chk(mem_valid_o && mem_addr_o == ea, "R7 stalled request held", mem_addr_o, ea);
        end
        if (mem_valid_o && mem_ready_i) begin
          if (k < n) begin
            ea = pr ? base - st * 32'(k + 1) : base + st * 32'(k);
            chk(mem_addr_o == ea, adr, mem_addr_o, ea);
            if (ld) begin
              ed = lg ? mem_val(ea) : {{16{mem_val(ea)[15]}}, mem_val(ea)[15:0]};
              chk(rf_we_o && !mem_we_o && int'(rf_waddr_o) == ord[k], ordr,
                  32'(rf_waddr_o), 32'(ord[k]));
              chk(rf_wdata_o == ed, "R5 load data", rf_wdata_o, ed);
            end else begin
              ed = lg ? reg_val(ord[k]) : {16'h0, reg_val(ord[k])[15:0]};
              chk(mem_we_o && !rf_we_o && int'(rf_raddr_o) == ord[k], ordr,
                  32'(rf_raddr_o), 32'(ord[k]));
              chk(mem_wdata_o == ed, "R4 store data", mem_wdata_o, ed);
            end
          end
          k++;
        end
      end
    end
    chk(seen, "R10 done seen", 32'(seen), 32'd1);
    chk(k == n, (n == 0) ? "R6 no request" : "R7 transfer count", 32'(k), 32'(n));
    ea = pr ? base - st * 32'(n) : base + st * 32'(n);
    chk(end_addr_o == ea, (n == 0) ? "R6 end addr" : (pr ? "R8 end addr" : "R9 end addr"),
        end_addr_o, ea);
    @(negedge clk); #1;
    chk(!done_o && !busy_o, "R10 done pulse ends", {30'b0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    #(8ns * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({mem_valid_o, done_o, busy_o, rf_we_o} == 4'b0, "R11 reset outputs",
        {28'b0, mem_valid_o, done_o, busy_o, rf_we_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy_o && !mem_valid_o, "R11 idle after reset", {30'b0, busy_o, mem_valid_o}, 32'd0);

    for (int v = 0; v < 8; v++)
      run_op(V_MASK[v], V_LD[v], V_LG[v], V_PRE[v], V_BASE[v], V_MODE[v], 0, 0);

    // R7 and R10: long stall with an ignored start strobe in the middle
    run_op(16'h8101, 1'b0, 1'b1, 1'b0, 32'h2000, 0, 5, 1);
    run_op(16'h0C03, 1'b1, 1'b0, 1'b1, 32'h6000, 1, 4, 1);
    // R6: empty mask in the predecrement load variant
    run_op(16'h0000, 1'b1, 1'b1, 1'b1, 32'h7000, 0, 0, 0);
    // R1: boundary between the last data and first address register
    run_op(16'h0180, 1'b0, 1'b0, 1'b0, 32'hA000, 2, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule